// File: doc/BRIEF.md
# Multi-Width Aliased Register File

This block holds sixteen 64-bit general-purpose registers that can all be addressed at the same time. There is no banking and no swap. Each register can be written or read as a whole 64-bit value, as its low 32 bits, as its low 16 bits, or as a single byte. The hardware applies the sub-register rules itself. A 32-bit write zero-extends into the full register. A 16-bit or 8-bit write merges into the stored value and leaves every bit outside its field unchanged.

Byte access carries a historical quirk. For 3-bit register numbers 0 to 3, the first four registers also have a high-byte alias covering bits 15:8. A per-access extension flag decides how byte indices 4 to 7 are read. With the flag clear, those indices name the high bytes of registers 0 to 3. With the flag set, they name the low bytes of registers 4 to 7. Registers 8 to 15 follow one uniform rule and have no high-byte form.

The block has one write port and two independent read ports. The read ports are combinational from the stored state. A read of a register that is being written in the same cycle therefore returns the value held before the write.

Top module: `rf_alias_regfile`

## Requirements
- R1: While `rst_n` is low, all sixteen registers are cleared to zero. After reset, every 64-bit read returns 0.
- R2: A write with width code 11 (64-bit) replaces all 64 bits of the register selected by the 4-bit index. All sixteen registers hold separate values, and a 64-bit read returns the stored value.
- R3: A write with width code 10 (32-bit) replaces bits 31:0 and forces bits 63:32 to zero. For example, 0xFFFFFFFF12345678 followed by a 32-bit write of 0 reads back as 0.
- R4: A write with width code 01 (16-bit) replaces bits 15:0 and keeps bits 63:16.
- R5: A write with width code 00 (8-bit) replaces bits 7:0 and keeps all other bits when the index is 0–3 or 8–15, whatever the value of the extension flag.
- R6: An 8-bit write to index 4–7 with the extension flag clear replaces bits 15:8 of register (index−4) and keeps its other bits. Register 4–7 itself is left unchanged.
- R7: An 8-bit write to index 4–7 with the extension flag set replaces bits 7:0 of register 4–7. Registers 0–3 are left unchanged.
- R8: Each read port applies the same index, width and extension decoding and returns the field zero-extended to 64 bits. An 8-bit read returns the byte in bits 7:0, a 16-bit read returns bits 15:0, and a 32-bit read returns bits 31:0.
- R9: A read of the register being written in the same cycle returns the old value. The new value appears after the next rising clock edge.
- R10: The extension flag has no effect on accesses with widths 01, 10 or 11, or on any access to index 0–3 or 8–15.
- R11: When `wr_en` is low, no register changes, whatever the other write inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write enable, sampled on the rising edge |
| wr_idx | input | 4 | Write register index |
| wr_width | input | 2 | Write width code: 00 byte, 01 16-bit, 10 32-bit, 11 64-bit |
| wr_ext | input | 1 | Write extension flag; reinterprets byte indices 4–7 |
| wr_data | input | 64 | Write data, with the field in its low bits |
| ra_idx | input | 4 | Read port A register index |
| ra_width | input | 2 | Read port A width code |
| ra_ext | input | 1 | Read port A extension flag |
| ra_data | output | 64 | Read port A field, zero-extended |
| rb_idx | input | 4 | Read port B register index |
| rb_width | input | 2 | Read port B width code |
| rb_ext | input | 1 | Read port B extension flag |
| rb_data | output | 64 | Read port B field, zero-extended |

## Verification
A write takes effect at the first rising edge after it is presented. Read data follows the read inputs combinationally, with no cycle of latency. The bench drives each write on a falling edge and removes it on the next falling edge, so exactly one rising edge commits it. It then sets the read inputs on a later falling edge and compares the outputs one nanosecond later, well away from any rising edge. The same-cycle case holds the write and the read together. It checks the old value before the committing edge and the new value after that edge.

// File: rtl/rf_alias_pkg.sv
package rf_alias_pkg;
  localparam int DATA_W = 64;
  localparam int NREGS  = 16;
  localparam int IDX_W  = $clog2(NREGS);
  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;
  localparam int WORD_W = 32;
  // Index bit that turns a legacy byte index 4..7 into a high-byte alias
  localparam int ALIAS_BIT = 2;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_FULL = 2'b11
  } size_e;
endpackage

// File: rtl/rf_alias_decode.sv
module rf_alias_decode
  import rf_alias_pkg::*;
#(
  parameter int IW = IDX_W
) (
  input  logic [IW-1:0] idx_i,
  input  logic [1:0]    size_i,
  input  logic          ext_i,
  output logic [IW-1:0] phys_o,
  output logic          hi_o
);
  logic legacy_range;
  logic alias_pos;

  always_comb begin
    // Only legacy indices (top bit clear) with the alias bit set can alias
    legacy_range = ~idx_i[IW-1];
    alias_pos    = idx_i[ALIAS_BIT];
    hi_o         = (size_i == SZ_BYTE) && !ext_i && legacy_range && alias_pos;
    phys_o       = idx_i;
    if (hi_o) begin
      phys_o[ALIAS_BIT] = 1'b0;
    end
  end
endmodule

// File: rtl/rf_write_merge.sv
module rf_write_merge
  import rf_alias_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic [DW-1:0] old_i,
  input  logic [DW-1:0] data_i,
  input  logic [1:0]    size_i,
  input  logic          hi_i,
  output logic [DW-1:0] new_o
);
  always_comb begin
    new_o = old_i;
    unique case (size_i)
      SZ_BYTE: begin
        if (hi_i) new_o[2*BYTE_W-1:BYTE_W] = data_i[BYTE_W-1:0];
        else      new_o[BYTE_W-1:0]        = data_i[BYTE_W-1:0];
      end
      SZ_HALF: new_o[HALF_W-1:0] = data_i[HALF_W-1:0];
      SZ_WORD: new_o = {{(DW-WORD_W){1'b0}}, data_i[WORD_W-1:0]};
      SZ_FULL: new_o = data_i;
      default: new_o = old_i;
    endcase
  end
endmodule

// File: rtl/rf_read_extract.sv
module rf_read_extract
  import rf_alias_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic [DW-1:0] q_i,
  input  logic [1:0]    size_i,
  input  logic          hi_i,
  output logic [DW-1:0] data_o
);
  always_comb begin
    data_o = '0;
    unique case (size_i)
      SZ_BYTE: begin
        if (hi_i) data_o[BYTE_W-1:0] = q_i[2*BYTE_W-1:BYTE_W];
        else      data_o[BYTE_W-1:0] = q_i[BYTE_W-1:0];
      end
      SZ_HALF: data_o[HALF_W-1:0] = q_i[HALF_W-1:0];
      SZ_WORD: data_o[WORD_W-1:0] = q_i[WORD_W-1:0];
      SZ_FULL: data_o = q_i;
      default: data_o = '0;
    endcase
  end
endmodule

// File: rtl/rf_alias_regfile.sv
module rf_alias_regfile
  import rf_alias_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NR = NREGS,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [1:0]    wr_width,
  input  logic          wr_ext,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] ra_idx,
  input  logic [1:0]    ra_width,
  input  logic          ra_ext,
  output logic [DW-1:0] ra_data,
  input  logic [IW-1:0] rb_idx,
  input  logic [1:0]    rb_width,
  input  logic          rb_ext,
  output logic [DW-1:0] rb_data
);
  localparam int NPORTS = 2;

  logic [NR-1:0][DW-1:0] regs_q;
  logic [NR-1:0]         reg_en;
  logic [DW-1:0]         merged;
  logic [IW-1:0]         wr_phys;
  logic                  wr_hi;

  // Write path: alias decode, merge with the target register's old value
  rf_alias_decode #(.IW(IW)) u_wr_dec (
    .idx_i (wr_idx),
    .size_i(wr_width),
    .ext_i (wr_ext),
    .phys_o(wr_phys),
    .hi_o  (wr_hi)
  );

  rf_write_merge #(.DW(DW)) u_merge (
    .old_i (regs_q[wr_phys]),
    .data_i(wr_data),
    .size_i(wr_width),
    .hi_i  (wr_hi),
    .new_o (merged)
  );

  always_comb begin
    reg_en = '0;
    if (wr_en) reg_en[wr_phys] = 1'b1;
  end

  for (genvar r = 0; r < NR; r++) begin : g_store
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[r] <= '0;
      end else if (reg_en[r]) begin
        regs_q[r] <= merged;
      end
    end
  end

  // Read paths: identical decode and extract per port
  logic [NPORTS-1:0][IW-1:0] rd_idx;
  logic [NPORTS-1:0][1:0]    rd_size;
  logic [NPORTS-1:0]         rd_ext;
  logic [NPORTS-1:0][DW-1:0] rd_out;

  assign rd_idx  = {rb_idx, ra_idx};
  assign rd_size = {rb_width, ra_width};
  assign rd_ext  = {rb_ext, ra_ext};
  assign ra_data = rd_out[0];
  assign rb_data = rd_out[1];

  for (genvar p = 0; p < NPORTS; p++) begin : g_rd
    logic [IW-1:0] phys;
    logic          hi;

    rf_alias_decode #(.IW(IW)) u_dec (
      .idx_i (rd_idx[p]),
      .size_i(rd_size[p]),
      .ext_i (rd_ext[p]),
      .phys_o(phys),
      .hi_o  (hi)
    );

    rf_read_extract #(.DW(DW)) u_ext (
      .q_i   (regs_q[phys]),
      .size_i(rd_size[p]),
      .hi_i  (hi),
      .data_o(rd_out[p])
    );
  end
endmodule

// File: rtl/rf_alias_regfile_chk.sv
module rf_alias_regfile_chk
  import rf_alias_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NR = NREGS,
  parameter int IW = IDX_W
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [IW-1:0]         wr_idx,
  input logic [1:0]            wr_width,
  input logic                  wr_ext,
  input logic [DW-1:0]         wr_data,
  input logic [IW-1:0]         ra_idx,
  input logic [1:0]            ra_width,
  input logic [DW-1:0]         ra_data,
  input logic [NR-1:0][DW-1:0] regs_q
);
  for (genvar i = 0; i < NR; i++) begin : g_reg
    // R3: 32-bit write zero-extends
    a_r3_word_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IW'(i) && wr_width == 2'b10)
      |=> (regs_q[i] == {{(DW-WORD_W){1'b0}}, $past(wr_data[WORD_W-1:0])}));

    // R4: 16-bit write keeps the upper bits
    a_r4_half_merge: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IW'(i) && wr_width == 2'b01)
      |=> (regs_q[i][DW-1:HALF_W] == $past(regs_q[i][DW-1:HALF_W]))
       && (regs_q[i][HALF_W-1:0] == $past(wr_data[HALF_W-1:0])));

    // R11: nothing changes without a write enable
    a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(regs_q[i]));

    if (i < 4) begin : g_alias
      // R6: legacy byte index i+4 writes the high byte of register i
      a_r6_high_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IW'(i + 4) && wr_width == 2'b00 && !wr_ext)
        |=> (regs_q[i][2*BYTE_W-1:BYTE_W] == $past(wr_data[BYTE_W-1:0]))
         && (regs_q[i][BYTE_W-1:0] == $past(regs_q[i][BYTE_W-1:0]))
         && (regs_q[i][DW-1:2*BYTE_W] == $past(regs_q[i][DW-1:2*BYTE_W]))
         && $stable(regs_q[i+4]));
    end
  end

  // R8: byte reads are zero-extended
  a_r8_byte_read_zext: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_width == 2'b00) |-> (ra_data[DW-1:BYTE_W] == '0));

  // R2: full-width read returns the stored register
  a_r2_full_read: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_width == 2'b11) |-> (ra_data == regs_q[ra_idx]));
endmodule

bind rf_alias_regfile rf_alias_regfile_chk #(.DW(DW), .NR(NR), .IW(IW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_idx  (wr_idx),
  .wr_width(wr_width),
  .wr_ext  (wr_ext),
  .wr_data (wr_data),
  .ra_idx  (ra_idx),
  .ra_width(ra_width),
  .ra_data (ra_data),
  .regs_q  (regs_q)
);

// File: tb/rf_alias_regfile_test.sv
`timescale 1ns/1ps
module rf_alias_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_idx;
  logic [1:0]  wr_width;
  logic        wr_ext;
  logic [63:0] wr_data;
  logic [3:0]  ra_idx, rb_idx;
  logic [1:0]  ra_width, rb_width;
  logic        ra_ext, rb_ext;
  logic [63:0] ra_data, rb_data;

  int n_checks = 0;
  int n_fails  = 0;

  always #4 clk = ~clk;

  rf_alias_regfile uut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_width(wr_width), .wr_ext(wr_ext), .wr_data(wr_data),
    .ra_idx(ra_idx), .ra_width(ra_width), .ra_ext(ra_ext), .ra_data(ra_data),
    .rb_idx(rb_idx), .rb_width(rb_width), .rb_ext(rb_ext), .rb_data(rb_data)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [1:0] w, input logic ext, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_width = w; wr_ext = ext; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_a(input logic [3:0] idx, input logic [1:0] w, input logic ext, output logic [63:0] q);
    @(negedge clk);
    ra_idx = idx; ra_width = w; ra_ext = ext;
    #1 q = ra_data;
  endtask

  task automatic rd_b(input logic [3:0] idx, input logic [1:0] w, input logic ext, output logic [63:0] q);
    @(negedge clk);
    rb_idx = idx; rb_width = w; rb_ext = ext;
    #1 q = rb_data;
  endtask

  function automatic logic [63:0] pat(input int i);
    return 64'h0123_4567_89AB_CDEF ^ (64'(i) * 64'h0101_0101_0101_0101);
  endfunction

  task automatic t_reset;
    logic [63:0] q;
    for (int i = 0; i < 16; i++) begin
      rd_a(4'(i), 2'b11, 1'b0, q);
      check("R1 reset clear", q, 64'h0);
    end
  endtask

  task automatic t_full;
    logic [63:0] q;
    for (int i = 0; i < 16; i++) wr(4'(i), 2'b11, 1'b0, pat(i));
    for (int i = 0; i < 16; i++) begin
      rd_a(4'(i), 2'b11, 1'b0, q);
      check("R2 full write", q, pat(i));
    end
    rd_b(4'd13, 2'b11, 1'b1, q);
    check("R2 port b full read", q, pat(13));
  endtask

  task automatic t_word;
    logic [63:0] q;
    wr(4'd0, 2'b11, 1'b0, 64'hFFFF_FFFF_1234_5678);
    wr(4'd0, 2'b10, 1'b0, 64'h0);
    rd_a(4'd0, 2'b11, 1'b0, q);
    check("R3 word write of zero", q, 64'h0);
    wr(4'd12, 2'b11, 1'b0, 64'hAAAA_AAAA_AAAA_AAAA);
    wr(4'd12, 2'b10, 1'b1, 64'h5555_5555_DEAD_BEEF);
    rd_a(4'd12, 2'b11, 1'b0, q);
    check("R3 word zero-extend", q, 64'h0000_0000_DEAD_BEEF);
  endtask

  task automatic t_half;
    logic [63:0] q;
    wr(4'd1, 2'b11, 1'b0, 64'h1122_3344_5566_7788);
    wr(4'd1, 2'b01, 1'b0, 64'hFFFF_FFFF_FFFF_BEEF);
    rd_a(4'd1, 2'b11, 1'b0, q);
    check("R4 half merge", q, 64'h1122_3344_5566_BEEF);
  endtask

  task automatic t_byte_lo;
    logic [63:0] q;
    wr(4'd2, 2'b11, 1'b0, 64'h1122_3344_5566_7788);
    wr(4'd2, 2'b00, 1'b0, 64'hFFFF_FFFF_FFFF_FFA5);
    rd_a(4'd2, 2'b11, 1'b0, q);
    check("R5 low byte idx2", q, 64'h1122_3344_5566_77A5);
    wr(4'd10, 2'b11, 1'b0, 64'h0F0F_0F0F_0F0F_0F0F);
    wr(4'd14, 2'b11, 1'b0, 64'h0);
    wr(4'd10, 2'b00, 1'b1, 64'h0000_0000_0000_00C6);
    rd_a(4'd10, 2'b11, 1'b0, q);
    check("R5 low byte idx10", q, 64'h0F0F_0F0F_0F0F_0FC6);
    wr(4'd14, 2'b00, 1'b0, 64'h0000_0000_0000_0077);
    rd_a(4'd14, 2'b11, 1'b0, q);
    check("R5 low byte idx14 no high alias", q, 64'h77);
  endtask

  task automatic t_byte_hi;
    logic [63:0] q;
    wr(4'd3, 2'b11, 1'b0, 64'h1122_3344_5566_7788);
    wr(4'd7, 2'b11, 1'b0, 64'h7777_7777_7777_7777);
    wr(4'd7, 2'b00, 1'b0, 64'h0000_0000_0000_005A);
    rd_a(4'd3, 2'b11, 1'b0, q);
    check("R6 high byte of reg3", q, 64'h1122_3344_5566_5A88);
    rd_a(4'd7, 2'b11, 1'b0, q);
    check("R6 reg7 untouched", q, 64'h7777_7777_7777_7777);
  endtask

  task automatic t_byte_ext;
    logic [63:0] q;
    wr(4'd1, 2'b11, 1'b0, 64'h1111_1111_1111_1111);
    wr(4'd5, 2'b11, 1'b0, 64'h5555_5555_5555_5555);
    wr(4'd5, 2'b00, 1'b1, 64'h0000_0000_0000_00C3);
    rd_a(4'd5, 2'b11, 1'b0, q);
    check("R7 low byte of reg5", q, 64'h5555_5555_5555_55C3);
    rd_a(4'd1, 2'b11, 1'b0, q);
    check("R7 reg1 untouched", q, 64'h1111_1111_1111_1111);
  endtask

  task automatic t_read_ext;
    logic [63:0] q;
    wr(4'd0, 2'b11, 1'b0, 64'h8877_6655_4433_2211);
    wr(4'd4, 2'b11, 1'b0, 64'hF0E0_D0C0_B0A0_9080);
    rd_a(4'd0, 2'b00, 1'b0, q); check("R8 byte read", q, 64'h11);
    rd_a(4'd4, 2'b00, 1'b0, q); check("R8 high byte read", q, 64'h22);
    rd_a(4'd4, 2'b00, 1'b1, q); check("R8 ext byte read", q, 64'h80);
    rd_a(4'd0, 2'b01, 1'b0, q); check("R8 half read", q, 64'h2211);
    rd_a(4'd0, 2'b10, 1'b0, q); check("R8 word read", q, 64'h4433_2211);
    rd_b(4'd4, 2'b00, 1'b0, q); check("R8 port b high byte", q, 64'h22);
    rd_b(4'd4, 2'b10, 1'b0, q); check("R8 port b word", q, 64'hB0A0_9080);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd9; wr_width = 2'b11; wr_ext = 1'b0; wr_data = 64'hCAFE_F00D_1234_0009;
    ra_idx = 4'd9; ra_width = 2'b11; ra_ext = 1'b0;
    #1 check("R9 old value same cycle", ra_data, pat(9));
    @(negedge clk);
    wr_en = 1'b0;
    #1 check("R9 new value next cycle", ra_data, 64'hCAFE_F00D_1234_0009);
  endtask

  task automatic t_ext_ignored;
    logic [63:0] q;
    wr(4'd6, 2'b11, 1'b1, 64'h6666_6666_6666_6666);
    wr(4'd6, 2'b01, 1'b1, 64'h0000_0000_0000_ABCD);
    rd_a(4'd6, 2'b11, 1'b0, q);
    check("R10 ext on half write", q, 64'h6666_6666_6666_ABCD);
    wr(4'd1, 2'b00, 1'b1, 64'h0000_0000_0000_00EE);
    rd_a(4'd1, 2'b11, 1'b0, q);
    check("R10 ext on low index byte write", q, 64'h1111_1111_1111_11EE);
    rd_a(4'd1, 2'b00, 1'b1, q);
    check("R10 ext on low index byte read", q, 64'hEE);
    rd_a(4'd6, 2'b01, 1'b0, q);
    check("R10 ext clear on half read", q, 64'hABCD);
  endtask

  task automatic t_wr_disabled;
    logic [63:0] q;
    @(negedge clk);
    wr_en = 1'b0; wr_idx = 4'd8; wr_width = 2'b11; wr_ext = 1'b0; wr_data = 64'hDEAD_DEAD_DEAD_DEAD;
    @(negedge clk);
    rd_a(4'd8, 2'b11, 1'b0, q);
    check("R11 no write when disabled", q, pat(8));
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_width = '0; wr_ext = 1'b0; wr_data = '0;
    ra_idx = '0; ra_width = 2'b11; ra_ext = 1'b0;
    rb_idx = '0; rb_width = 2'b11; rb_ext = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_full();
    t_wr_disabled();
    t_same_cycle();
    t_word();
    t_half();
    t_byte_lo();
    t_byte_hi();
    t_byte_ext();
    t_read_ext();
    t_ext_ignored();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule